// File: doc/BRIEF.md
# SPI Master Command-Queue Engine

This block is an SPI bus master that is driven entirely by queued command words. Software writes 32-bit commands into a small transmit queue through a register port. Each command carries the data to shift out, the chip-select line(s) to drive, which of four attribute sets to use, and three control flags: keep chip-select asserted afterwards, stop the queue after this frame, and zero the frame counter. The engine pulls commands one at a time and runs one frame per command, with the frame length, clock polarity, clock phase and bit order taken from the chosen attribute set. It pushes each received frame, right-aligned, into a receive queue that software pops through the same port.

When a command marked as the end of the queue finishes, a sticky status flag is raised and the engine stops fetching. That flag can drive an interrupt line. Writing one to the flag clears it, and the engine then continues with whatever is waiting in the transmit queue. The SPI clock runs at a fixed division of the system clock, set by a parameter.

Register word addresses on `regAddr`: 0 configuration, 1 status, 2 interrupt enable, 3 command push, 4 receive pop, 5 to 8 attribute sets 0 to 3, 9 frame counter.

Top module: `spi_cmdq_engine`

## Requirements
- R1: The transmit and receive queues each hold 4 entries. A push to a full transmit queue is discarded and sets status bit 0. A pop from an empty receive queue returns 0 and sets status bit 1. Writing 1 to either bit clears it.
- R2: Command word fields: bit 31 keeps chip-select asserted, bits 29:28 pick the attribute set, bit 27 ends the queue, bit 26 zeroes the frame counter, bits 21:16 are the one-hot chip-select mask, and bits 15:0 are the transmit data.
- R3: An attribute set stores frame length minus one in bits 30:27 (values below 3 are stored as 3, so frames are 4 to 16 bits long) and the bit order in bit 24 (1 = least significant bit first). Each frame shifts exactly that many bits out on `mosi` and in from `miso`, and the received value is popped right-aligned in bits 15:0.
- R4: Attribute bit 26 sets the idle level of `sck`. Attribute bit 25 = 0 samples on the leading edge of each bit and changes data on the trailing edge. Bit 25 = 1 changes data on the leading edge and samples on the trailing edge.
- R5: Each `pcs` pin rests at its inactive level, set by configuration bits 21:16. The masked pins take the opposite level from the start of a frame. They return to rest after the frame unless the command's keep bit was set, in which case they stay asserted until the next frame begins.
- R6: Completing a frame whose command has the end bit sets status bit 28. No command starts while bit 28 is set. Writing 1 to bit 28 clears it, and fetching resumes.
- R7: `irq` is high exactly while status bit 28 and interrupt-enable bit 28 are both set.
- R8: The 16-bit frame counter at address 9 adds one for each completed frame. It is zeroed as a frame with the counter-clear bit starts, so it reads 1 after that frame alone.
- R9: Configuration bit 31 enables the engine. While it is 0, no command starts. It resets to 0.
- R10: Writing 1 to configuration bit 11 empties the transmit queue, and writing 1 to bit 10 empties the receive queue. Neither bit is stored, and both read back as 0.
- R11: After reset, configuration reads 0x003F0000, status and interrupt-enable read 0, each attribute set reads an 8-bit frame (0x38000000), the counter reads 0, `pcs` is 0x3F and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register word address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (pops the receive queue at address 4) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| pcs | output | 6 | Chip-select pins |
| irq | output | 1 | End-of-queue interrupt |

## Verification
If the shift register or bit counter goes wrong, the error shows up on `mosi` within the same frame: a wrong bit, or a wrong number of clock edges while chip-select is asserted. The same fault also shows up at the next receive-queue pop, because `miso` is looped back. If the halt logic fails, an SPI edge appears while the end flag is still set, or the flag never rises, within one frame time. Faults in the chip-select hold or release show on `pcs` as soon as the frame closes. Faults in the queue pointers show up as wrong or missing pops, or as a wrong status bit, on the next register read.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;

  localparam int DATA_W = 16;
  localparam int CS_W   = 6;
  localparam int ATTR_N = 4;

  localparam logic [3:0] ADDR_CFG   = 4'd0;
  localparam logic [3:0] ADDR_STAT  = 4'd1;
  localparam logic [3:0] ADDR_IEN   = 4'd2;
  localparam logic [3:0] ADDR_PUSH  = 4'd3;
  localparam logic [3:0] ADDR_POP   = 4'd4;
  localparam logic [3:0] ADDR_ATTR0 = 4'd5;
  localparam logic [3:0] ADDR_CNT   = 4'd9;

  typedef struct packed {
    logic [3:0] sizeM1;
    logic       cpol;
    logic       cpha;
    logic       lsbFirst;
  } attr_t;

  typedef struct packed {
    logic load;
    logic edgeEv;
    logic shiftOut;
    logic sampleIn;
    logic done;
  } ctrlStrb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN, ST_HOLD} engState_t;

endpackage

// File: rtl/spi_cmdq_fifo.sv
module spi_cmdq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wrData;
  end

  a_r1_pop_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !push && !flush) |=> empty);

endmodule

// File: rtl/spi_cmdq_ctrl.sv
module spi_cmdq_ctrl
  import spi_cmdq_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  logic       masterEn,
  input  logic       eoqHalt,
  input  logic [3:0] frameSizeM1,
  input  logic       frameCpha,
  input  logic       frameCont,
  output ctrlStrb_t  strb,
  output logic       csOn
);
  localparam int TW = $clog2(HALF_CYC) + 1;

  engState_t   state;
  logic [TW-1:0] timer;
  logic [4:0]  edgeCnt;
  logic [4:0]  lastEdge;
  logic        keepCs;
  logic        tick;
  logic        leading;

  assign tick     = (timer == TW'(HALF_CYC - 1));
  assign lastEdge = {frameSizeM1, 1'b1};
  assign leading  = !edgeCnt[0];
  assign csOn     = (state != ST_IDLE) || keepCs;

  always_comb begin
    strb          = '0;
    strb.load     = (state == ST_IDLE) && txValid && masterEn && !eoqHalt;
    strb.edgeEv   = (state == ST_RUN) && tick;
    strb.sampleIn = strb.edgeEv && (leading ^ frameCpha);
    strb.shiftOut = strb.edgeEv && !(leading ^ frameCpha);
    strb.done     = (state == ST_HOLD) && tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      edgeCnt <= '0;
      keepCs  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state  <= ST_SETUP;
            timer  <= '0;
            keepCs <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state   <= ST_RUN;
            timer   <= '0;
            edgeCnt <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_RUN: begin
          if (tick) begin
            timer <= '0;
            if (edgeCnt == lastEdge) state <= ST_HOLD;
            else edgeCnt <= edgeCnt + 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            state  <= ST_IDLE;
            timer  <= '0;
            keepCs <= frameCont;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r6_idle_while_halted: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && eoqHalt) |=> (state == ST_IDLE));

  a_r3_frame_edge_total: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> (edgeCnt == lastEdge));

  a_r5_cs_kept_after_cont: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && frameCont) |=> csOn);

endmodule

// File: rtl/spi_cmdq_datapath.sv
module spi_cmdq_datapath
  import spi_cmdq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  ctrlStrb_t        strb,
  input  logic             csOn,
  output logic             txValid,
  output logic             masterEn,
  output logic             eoqHalt,
  output logic [3:0]       frameSizeM1,
  output logic             frameCpha,
  output logic             frameCont,
  input  logic             miso,
  output logic             mosi,
  output logic             sck,
  output logic [CS_W-1:0]  pcs,
  output logic             irq
);
  localparam logic [3:0] MIN_SIZE_M1 = 4'd3;

  logic              cfgMaster;
  logic [CS_W-1:0]   cfgInactive;
  logic              irqEn, eoqFlag, ovfFlag, udfFlag;
  attr_t             attrReg [ATTR_N];
  attr_t             curAttr, headAttr;
  logic [CS_W-1:0]   curMask;
  logic              curCont, curEoq;
  logic [DATA_W-1:0] txShift, rxShift, rxAligned, headData, msbAligned;
  logic              mosiReg, sckReg;
  logic [CNT_W-1:0]  xferCnt;

  logic        wrCfg, wrStat, wrIen, pushReq, popReq;
  logic [31:0] txHead;
  logic [DATA_W-1:0] rxHead;
  logic        txFull, txEmpty, rxFull, rxEmpty;
  logic        unusedCmdBits;
  logic        unusedRxFull;

  assign wrCfg   = regWr && (regAddr == ADDR_CFG);
  assign wrStat  = regWr && (regAddr == ADDR_STAT);
  assign wrIen   = regWr && (regAddr == ADDR_IEN);
  assign pushReq = regWr && (regAddr == ADDR_PUSH);
  assign popReq  = regRd && (regAddr == ADDR_POP);

  spi_cmdq_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) txQueue (
    .clk(clk), .rstN(rstN), .flush(wrCfg && regWrData[11]),
    .push(pushReq), .pop(strb.load), .wrData(regWrData),
    .rdData(txHead), .full(txFull), .empty(txEmpty)
  );

  spi_cmdq_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN), .flush(wrCfg && regWrData[10]),
    .push(strb.done), .pop(popReq), .wrData(rxAligned),
    .rdData(rxHead), .full(rxFull), .empty(rxEmpty)
  );

  assign unusedCmdBits = ^{txHead[30], txHead[25:22]};
  assign unusedRxFull  = rxFull;

  // attribute sets, one register per index
  for (genvar g = 0; g < ATTR_N; g++) begin : gAttr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        attrReg[g] <= '{sizeM1: 4'd7, cpol: 1'b0, cpha: 1'b0, lsbFirst: 1'b0};
      end else if (regWr && (regAddr == ADDR_ATTR0 + 4'(g))) begin
        attrReg[g].sizeM1   <= (regWrData[30:27] < MIN_SIZE_M1) ? MIN_SIZE_M1 : regWrData[30:27];
        attrReg[g].cpol     <= regWrData[26];
        attrReg[g].cpha     <= regWrData[25];
        attrReg[g].lsbFirst <= regWrData[24];
      end
    end
  end

  assign headAttr   = attrReg[txHead[29:28]];
  assign headData   = txHead[15:0];
  assign msbAligned = headData << (4'd15 - headAttr.sizeM1);
  assign rxAligned  = curAttr.lsbFirst ? (rxShift >> (4'd15 - curAttr.sizeM1)) : rxShift;

  // configuration and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMaster   <= 1'b0;
      cfgInactive <= '1;
      irqEn       <= 1'b0;
      eoqFlag     <= 1'b0;
      ovfFlag     <= 1'b0;
      udfFlag     <= 1'b0;
    end else begin
      if (wrCfg) begin
        cfgMaster   <= regWrData[31];
        cfgInactive <= regWrData[21:16];
      end
      if (wrIen) irqEn <= regWrData[28];
      if (wrStat && regWrData[28]) eoqFlag <= 1'b0;
      if (wrStat && regWrData[0])  ovfFlag <= 1'b0;
      if (wrStat && regWrData[1])  udfFlag <= 1'b0;
      if (strb.done && curEoq)     eoqFlag <= 1'b1;
      if (pushReq && txFull)       ovfFlag <= 1'b1;
      if (popReq && rxEmpty)       udfFlag <= 1'b1;
    end
  end

  // frame shifter, serial clock and counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAttr <= '{sizeM1: 4'd7, cpol: 1'b0, cpha: 1'b0, lsbFirst: 1'b0};
      curMask <= '0;
      curCont <= 1'b0;
      curEoq  <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      mosiReg <= 1'b0;
      sckReg  <= 1'b0;
      xferCnt <= '0;
    end else begin
      if (strb.load) begin
        curAttr <= headAttr;
        curMask <= txHead[21:16];
        curCont <= txHead[31];
        curEoq  <= txHead[27];
        sckReg  <= headAttr.cpol;
        rxShift <= '0;
        if (txHead[26]) xferCnt <= '0;
        if (!headAttr.cpha) begin
          mosiReg <= headAttr.lsbFirst ? headData[0] : msbAligned[DATA_W-1];
          txShift <= headAttr.lsbFirst ? (headData >> 1) : (msbAligned << 1);
        end else begin
          txShift <= headAttr.lsbFirst ? headData : msbAligned;
        end
      end
      if (strb.edgeEv) sckReg <= !sckReg;
      if (strb.shiftOut) begin
        mosiReg <= curAttr.lsbFirst ? txShift[0] : txShift[DATA_W-1];
        txShift <= curAttr.lsbFirst ? (txShift >> 1) : (txShift << 1);
      end
      if (strb.sampleIn)
        rxShift <= curAttr.lsbFirst ? {miso, rxShift[DATA_W-1:1]} : {rxShift[DATA_W-2:0], miso};
      if (strb.done) xferCnt <= xferCnt + 1'b1;
    end
  end

  assign txValid     = !txEmpty;
  assign masterEn    = cfgMaster;
  assign eoqHalt     = eoqFlag;
  assign frameSizeM1 = curAttr.sizeM1;
  assign frameCpha   = curAttr.cpha;
  assign frameCont   = curCont;
  assign mosi        = mosiReg;
  assign sck         = sckReg;
  assign pcs         = cfgInactive ^ (csOn ? curMask : '0);
  assign irq         = eoqFlag && irqEn;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CFG:  regRdData = {cfgMaster, 9'd0, cfgInactive, 16'd0};
      ADDR_STAT: regRdData = {3'd0, eoqFlag, 26'd0, udfFlag, ovfFlag};
      ADDR_IEN:  regRdData = {3'd0, irqEn, 28'd0};
      ADDR_POP:  regRdData = rxEmpty ? 32'd0 : {16'd0, rxHead};
      ADDR_CNT:  regRdData = {{(32-CNT_W){1'b0}}, xferCnt};
      4'd5, 4'd6, 4'd7, 4'd8: begin
        regRdData = {1'b0, attrReg[2'(regAddr - ADDR_ATTR0)], 24'd0};
      end
      default:   regRdData = '0;
    endcase
  end

  a_r1_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && txFull) |=> ovfFlag);

  a_r1_underflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && rxEmpty) |=> udfFlag);

  a_r6_eoq_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && curEoq) |=> eoqFlag);

  a_r6_no_start_halted: assert property (@(posedge clk) disable iff (!rstN)
    eoqFlag |-> !strb.load);

  a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMaster |-> !strb.load);

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> (xferCnt == $past(xferCnt) + 1'b1));

endmodule

// File: rtl/spi_cmdq_engine.sv
module spi_cmdq_engine
  import spi_cmdq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 4,
  parameter int SCK_HALF_CYC = 2,
  parameter int CNT_W        = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic [5:0]  pcs,
  output logic        irq
);
  ctrlStrb_t  strb;
  logic       csOn, txValid, masterEn, eoqHalt, frameCpha, frameCont;
  logic [3:0] frameSizeM1;

  spi_cmdq_ctrl #(.HALF_CYC(SCK_HALF_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .masterEn(masterEn),
    .eoqHalt(eoqHalt), .frameSizeM1(frameSizeM1), .frameCpha(frameCpha),
    .frameCont(frameCont), .strb(strb), .csOn(csOn)
  );

  spi_cmdq_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb), .csOn(csOn),
    .txValid(txValid), .masterEn(masterEn), .eoqHalt(eoqHalt),
    .frameSizeM1(frameSizeM1), .frameCpha(frameCpha), .frameCont(frameCont),
    .miso(miso), .mosi(mosi), .sck(sck), .pcs(pcs), .irq(irq)
  );

endmodule

// File: tb/tb_spi_cmdq_engine.sv
module tb_spi_cmdq_engine;

  localparam logic [5:0] INACT = 6'h3F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sck, mosi, irq;
  logic [5:0]  pcs;

  spi_cmdq_engine dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .miso(mosi),
    .sck(sck), .mosi(mosi), .pcs(pcs), .irq(irq)
  );

  always #4 clk = !clk;

  typedef struct {
    logic [15:0] data;
    int          n;
    bit          lsb;
    bit          cpha;
    bit          cpol;
    logic [5:0]  mask;
  } frame_t;

  frame_t       expFrames[$];
  logic [15:0]  expRx[$];
  int           aSize[4];
  bit           aCpol[4], aCpha[4], aLsb[4];
  int           total = 0, failed = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  // ---- reference serial slave: captures mosi per frame, checks against expectations
  logic        prevCs = 1'b0, prevSck = 1'b0, csNow;
  int          edgeIdx = 0, bitIdx = 0;
  logic [15:0] capVal = '0;
  frame_t      cur;

  always @(negedge clk) begin
    csNow = (pcs !== INACT);
    if (rstN && prevCs && csNow && (sck !== prevSck)) begin
      if (expFrames.size() == 0) begin
        chk("R3 unexpected sck edge", 32'd1, 32'd0);
      end else begin
        cur = expFrames[0];
        if (edgeIdx == 0) chk("R4 idle clock level", 32'(prevSck), 32'(cur.cpol));
        if (((edgeIdx % 2) == 0) != cur.cpha) begin
          if (cur.lsb) capVal[bitIdx] = mosi;
          else capVal = {capVal[14:0], mosi};
          bitIdx++;
        end
        edgeIdx++;
        if (edgeIdx == 2 * cur.n) begin
          chk("R3 R4 serial frame bits", 32'(capVal), 32'(cur.data));
          chk("R5 chip select during frame", 32'(pcs), 32'(INACT ^ cur.mask));
          void'(expFrames.pop_front());
          edgeIdx = 0; bitIdx = 0; capVal = '0;
        end
      end
    end
    prevCs = csNow;
    prevSck = sck;
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  function automatic logic [31:0] mkAttr(input int n, input bit cpol, input bit cpha, input bit lsb);
    return {1'b0, 4'(n - 1), cpol, cpha, lsb, 24'd0};
  endfunction

  function automatic logic [31:0] mkCmd(input bit cont, input int attr, input bit eoq,
                                        input bit clr, input int cs, input logic [15:0] d);
    return {cont, 1'b0, 2'(attr), eoq, clr, 4'd0, 6'(1 << cs), d};
  endfunction

  task automatic setAttr(input int i, input int n, input bit cpol, input bit cpha, input bit lsb);
    regWrite(4'(5 + i), mkAttr(n, cpol, cpha, lsb));
    aSize[i] = n; aCpol[i] = cpol; aCpha[i] = cpha; aLsb[i] = lsb;
  endtask

  task automatic pushCmd(input bit cont, input int attr, input bit eoq, input bit clr,
                         input int cs, input logic [15:0] d);
    frame_t f;
    logic [15:0] m;
    m = 16'((32'd1 << aSize[attr]) - 1);
    f.data = d & m; f.n = aSize[attr]; f.lsb = aLsb[attr];
    f.cpha = aCpha[attr]; f.cpol = aCpol[attr]; f.mask = 6'(1 << cs);
    expFrames.push_back(f);
    expRx.push_back(d & m);
    regWrite(4'd3, mkCmd(cont, attr, eoq, clr, cs, d));
  endtask

  task automatic waitIrq(input string tag);
    int n = 0;
    while (irq !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(tag, 32'(irq), 32'd1);
  endtask

  task automatic popCheck(input string tag);
    logic [31:0] v;
    logic [15:0] e;
    e = expRx.pop_front();
    regRead(4'd4, v);
    chk(tag, v, {16'd0, e});
  endtask

  logic [31:0] rd;

  initial begin
    for (int i = 0; i < 4; i++) begin aSize[i] = 8; aCpol[i] = 0; aCpha[i] = 0; aLsb[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 pcs at reset", 32'(pcs), 32'h3F);
    chk("R11 irq at reset", 32'(irq), 32'd0);
    regRead(4'd0, rd); chk("R11 R9 config reset", rd, 32'h003F0000);
    regRead(4'd1, rd); chk("R11 status reset", rd, 32'd0);
    regRead(4'd2, rd); chk("R11 irq enable reset", rd, 32'd0);
    regRead(4'd7, rd); chk("R11 attribute reset", rd, 32'h38000000);
    regRead(4'd9, rd); chk("R11 counter reset", rd, 32'd0);

    // setup
    regWrite(4'd0, 32'h803F0000);
    regWrite(4'd2, 32'h10000000);
    setAttr(0, 8, 0, 0, 0);
    setAttr(1, 12, 1, 1, 1);
    setAttr(2, 4, 0, 1, 0);
    setAttr(3, 16, 1, 0, 0);
    regWrite(4'd8, 32'h08000000);
    regRead(4'd8, rd); chk("R3 short size clamped", rd, 32'h18000000);
    setAttr(3, 16, 1, 0, 0);

    // R2 R3 R8 basic chain; R5 release after last frame
    pushCmd(1, 0, 0, 0, 0, 16'h00A5);
    pushCmd(0, 0, 0, 1, 0, 16'h003C);
    pushCmd(0, 0, 1, 0, 1, 16'h00F1);
    waitIrq("R6 R7 end flag raises irq");
    regRead(4'd1, rd); chk("R6 status end flag", rd, 32'h10000000);
    regRead(4'd9, rd); chk("R8 counter after clear", rd, 32'd2);
    chk("R5 release after frame", 32'(pcs), 32'h3F);
    popCheck("R3 rx 8-bit frame 1");
    popCheck("R3 rx 8-bit frame 2");
    popCheck("R3 rx 8-bit frame 3");

    // R6 halt while flag set, then resume
    pushCmd(0, 1, 1, 0, 2, 16'h0ABC);
    repeat (100) @(negedge clk);
    chk("R6 no start while halted", 32'(expFrames.size()), 32'd1);
    chk("R6 pcs idle while halted", 32'(pcs), 32'h3F);
    regWrite(4'd1, 32'h10000000);
    regRead(4'd1, rd); chk("R6 flag cleared by write one", rd, 32'd0);
    waitIrq("R6 resumed frame ends queue");
    popCheck("R3 R4 rx 12-bit lsb-first phase 1");

    // R7 interrupt masking
    regWrite(4'd2, 32'd0);
    regWrite(4'd1, 32'h10000000);
    pushCmd(0, 2, 1, 0, 3, 16'h0009);
    repeat (80) @(negedge clk);
    regRead(4'd1, rd); chk("R6 flag with irq masked", rd, 32'h10000000);
    chk("R7 irq masked", 32'(irq), 32'd0);
    regWrite(4'd2, 32'h10000000);
    chk("R7 irq unmasked", 32'(irq), 32'd1);
    popCheck("R3 rx 4-bit frame");
    regWrite(4'd1, 32'h10000000);

    // R5 continuous select held, then released
    pushCmd(1, 3, 1, 0, 4, 16'hBEEF);
    waitIrq("R6 16-bit frame ends");
    chk("R5 select held after keep frame", 32'(pcs), 32'(INACT ^ 6'h10));
    regWrite(4'd1, 32'h10000000);
    pushCmd(0, 3, 1, 0, 4, 16'h1234);
    waitIrq("R6 second 16-bit frame ends");
    chk("R5 select released", 32'(pcs), 32'h3F);
    popCheck("R3 rx 16-bit frame 1");
    popCheck("R3 rx 16-bit frame 2");
    regWrite(4'd1, 32'h10000000);

    // R9 engine disabled, R1 overflow, R10 transmit flush
    regWrite(4'd0, 32'h003F0000);
    for (int i = 0; i < 5; i++) regWrite(4'd3, mkCmd(0, 0, 1, 0, 0, 16'(i)));
    repeat (50) @(negedge clk);
    chk("R9 no frame while disabled", 32'(pcs), 32'h3F);
    regRead(4'd1, rd); chk("R1 overflow flag", rd, 32'h00000001);
    regWrite(4'd1, 32'h00000001);
    regWrite(4'd0, 32'h003F0800);
    regWrite(4'd0, 32'h803F0000);
    repeat (60) @(negedge clk);
    regRead(4'd1, rd); chk("R10 transmit flush leaves nothing", rd, 32'd0);
    regRead(4'd0, rd); chk("R10 flush bits not stored", rd, 32'h803F0000);
    pushCmd(0, 0, 1, 1, 5, 16'h005A);
    waitIrq("R1 queue usable after flush");
    popCheck("R3 rx after flush");
    regRead(4'd9, rd); chk("R8 counter cleared by command", rd, 32'd1);
    regWrite(4'd1, 32'h10000000);

    // R10 receive flush, R1 underflow
    pushCmd(0, 0, 0, 0, 0, 16'h0011);
    pushCmd(0, 0, 1, 0, 0, 16'h0022);
    waitIrq("R6 two frames end");
    regWrite(4'd0, 32'h803F0400);
    expRx.delete();
    regRead(4'd4, rd); chk("R10 R1 pop after rx flush", rd, 32'd0);
    regRead(4'd1, rd); chk("R1 underflow flag", rd, 32'h10000002);
    regWrite(4'd1, 32'h10000003);
    regRead(4'd1, rd); chk("R1 flags cleared", rd, 32'd0);

    chk("R3 all frames observed", 32'(expFrames.size()), 32'd0);
    finishRun();
  end

endmodule